// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block turns an addressing-mode code, the program counter of the operand's first byte and the two index values into the effective operand address of an 8-bit processor. It issues its own single-byte reads to fetch the operand bytes and any page-zero pointer bytes. It adds the index with the wrap rule of each mode. The result comes with the number of operand bytes the instruction carries and a flag that says whether indexing moved the address into another 256-byte page.

A decoder pulses `start` with the mode, PC and index values. The block then drives its read port, and `done` rises for one cycle with the result. The result outputs keep their value until the next result is produced. The read port has a fixed latency of one cycle: a byte requested with `rd_en` high at a clock edge must be on `rd_data` after that edge. Indexing inside page zero wraps within the first 256 bytes, while indexing of a full 16-bit base wraps around the whole 64 KiB space.

The controller is a state machine with six states. IDLE waits for `start`. It goes to FINISH directly for the immediate and no-operand codes, and to OPND_LO otherwise. OPND_LO receives the first operand byte. From there it goes to OPND_HI for the absolute family, to PTR_LO for the two indirect modes, and to FINISH for the page-zero modes. OPND_HI goes to FINISH once the high operand byte has been received. PTR_LO receives the pointer's low byte and goes to PTR_HI. PTR_HI receives the pointer's high byte and goes to FINISH. FINISH raises `done` and always returns to IDLE.

Top module: `opnd_addr_seq`

## Requirements
- R1: `start` is taken only in IDLE, where mode, PC and indices are latched. `done` is high for exactly one cycle. The number of rising edges from the edge that samples `start` to the first sample with `done` high is 1 for immediate and no-operand codes, 2 for codes 1 to 3, 3 for codes 4 to 6, and 4 for codes 7 and 8.
- R2: Mode code 0 (immediate) returns the PC itself as the address, issues no read, and reports 1 operand byte.
- R3: Code 1 (page zero) returns {0x00, op}, where op is the byte at PC. Code 2 (page zero plus X) and code 3 (page zero plus Y) return {0x00, (op + index) mod 256}. All three report 1 operand byte, and the high byte of the result is always zero.
- R4: Code 4 (absolute) reads the low byte at PC and the high byte at (PC+1) mod 65536, and returns {high, low}. It reports 2 operand bytes.
- R5: Code 5 (absolute plus X) and code 6 (absolute plus Y) return the absolute base plus the zero-extended index, mod 65536. They report 2 operand bytes.
- R6: Code 7 (indexed indirect) forms ptr = (op + X) mod 256. It reads the low byte at {0x00, ptr} and the high byte at {0x00, (ptr+1) mod 256}, and returns {high, low}. It reports 1 operand byte, and every pointer read stays in page zero.
- R7: Code 8 (indirect indexed) reads the base low byte at {0x00, op} and the high byte at {0x00, (op+1) mod 256}. It returns base + Y mod 65536 and reports 1 operand byte.
- R8: `page_cross` is 1 only for codes 5, 6 and 8, and only when the high byte of the result differs from the high byte of the base. For all other codes it is 0.
- R9: Codes 9 to 15 are no-operand codes. They give `mode_err` = 1, address 0x0000, 0 operand bytes and `page_cross` = 0. For codes 0 to 8, `mode_err` is 0.
- R10: The read data is taken one cycle after `rd_en`. The number of reads per request is 0 for code 0 and codes 9 to 15, 1 for codes 1 to 3, 2 for codes 4 to 6, and 3 for codes 7 and 8.
- R11: The result outputs stay unchanged after `done` until the next result. A `start` pulse while a request is in progress is ignored and produces no extra `done`.
- R12: While reset is held low and just after it is released, `done`, `rd_en`, `page_cross` and `mode_err` are 0, and `eff_addr` and `opnd_bytes` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken in IDLE |
| mode | input | 4 | Addressing-mode code (0 to 8 valid, 9 to 15 no operand) |
| pc | input | 16 | Address of the first operand byte |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| rd_en | output | 1 | Byte read request |
| rd_addr | output | 16 | Byte read address |
| rd_data | input | 8 | Read data, valid one cycle after `rd_en` |
| done | output | 1 | One-cycle result strobe |
| eff_addr | output | 16 | Effective address, held after `done` |
| opnd_bytes | output | 2 | Operand byte count of the mode |
| page_cross | output | 1 | Indexing changed the high byte |
| mode_err | output | 1 | No-operand mode code was given |

## Verification
The bench aims at the wrap boundaries, where a design that used a single adder width for every mode would go wrong:
- A page-zero index sum above 0xFF would leak into page one.
- A pointer at 0xFF would fetch its high byte from 0x0100 instead of 0x0000.
- An absolute operand at PC 0xFFFF would take its high byte from the wrong place.

It also drives bases whose index sum carries into or wraps out of the high byte. A page-cross flag compared against the wrong base, or raised for unindexed modes, shows up as a flag mismatch there. No-operand codes check that the address and byte count are zeroed. A `start` pulse in the middle of an indirect fetch would produce a second strobe or a corrupted address if it were not ignored.

// File: rtl/opnd_addr_pkg.sv
package opnd_addr_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] AM_IMM = 4'd0;
    localparam logic [MODE_W-1:0] AM_ZPG = 4'd1;
    localparam logic [MODE_W-1:0] AM_ZPX = 4'd2;
    localparam logic [MODE_W-1:0] AM_ZPY = 4'd3;
    localparam logic [MODE_W-1:0] AM_ABS = 4'd4;
    localparam logic [MODE_W-1:0] AM_ABX = 4'd5;
    localparam logic [MODE_W-1:0] AM_ABY = 4'd6;
    localparam logic [MODE_W-1:0] AM_INX = 4'd7;
    localparam logic [MODE_W-1:0] AM_INY = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_OPND_LO = 3'd1,
        ST_OPND_HI = 3'd2,
        ST_PTR_LO  = 3'd3,
        ST_PTR_HI  = 3'd4,
        ST_FINISH  = 3'd5
    } seq_state_t;

    function automatic logic needs_operand(input logic [MODE_W-1:0] m);
        return (m >= AM_ZPG) && (m <= AM_INY);
    endfunction

    function automatic logic is_abs_family(input logic [MODE_W-1:0] m);
        return (m >= AM_ABS) && (m <= AM_ABY);
    endfunction

    function automatic logic is_ind_family(input logic [MODE_W-1:0] m);
        return (m == AM_INX) || (m == AM_INY);
    endfunction

endpackage

// File: rtl/opnd_addr_calc.sv
module opnd_addr_calc
    import opnd_addr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [2*DW-1:0]   base,
    input  logic [DW-1:0]     idx_x,
    input  logic [DW-1:0]     idx_y,
    output logic [2*DW-1:0]   eff,
    output logic              page_cross,
    output logic [1:0]        nbytes,
    output logic              mode_err
);
    localparam int AW = 2 * DW;

    logic [DW-1:0] idx;
    logic          zp_idx;
    logic          full_idx;
    logic [DW-1:0] zp_sum;
    logic [AW-1:0] full_sum;

    always_comb begin
        idx      = '0;
        zp_idx   = 1'b0;
        full_idx = 1'b0;
        mode_err = 1'b0;
        nbytes   = 2'd1;
        unique case (mode)
            AM_IMM, AM_ZPG, AM_INX: ;
            AM_ZPX: begin idx = idx_x; zp_idx = 1'b1; end
            AM_ZPY: begin idx = idx_y; zp_idx = 1'b1; end
            AM_ABS: nbytes = 2'd2;
            AM_ABX: begin idx = idx_x; full_idx = 1'b1; nbytes = 2'd2; end
            AM_ABY: begin idx = idx_y; full_idx = 1'b1; nbytes = 2'd2; end
            AM_INY: begin idx = idx_y; full_idx = 1'b1; end
            default: begin mode_err = 1'b1; nbytes = 2'd0; end
        endcase
    end

    assign zp_sum   = base[DW-1:0] + idx;
    assign full_sum = base + {{DW{1'b0}}, idx};

    always_comb begin
        if (mode_err)      eff = '0;
        else if (zp_idx)   eff = {{DW{1'b0}}, zp_sum};
        else if (full_idx) eff = full_sum;
        else               eff = base;
    end

    assign page_cross = full_idx && (full_sum[AW-1:DW] != base[AW-1:DW]);

endmodule

// File: rtl/opnd_addr_fsm.sv
module opnd_addr_fsm
    import opnd_addr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [2*DW-1:0]   pc,
    input  logic [DW-1:0]     idx_x,
    input  logic [DW-1:0]     idx_y,
    output logic              rd_en,
    output logic [2*DW-1:0]   rd_addr,
    input  logic [DW-1:0]     rd_data,
    output logic [MODE_W-1:0] c_mode,
    output logic [2*DW-1:0]   c_base,
    output logic [DW-1:0]     c_x,
    output logic [DW-1:0]     c_y,
    input  logic [2*DW-1:0]   c_eff,
    input  logic              c_page,
    input  logic [1:0]        c_bytes,
    input  logic              c_err,
    output logic              done,
    output logic [2*DW-1:0]   eff_addr,
    output logic [1:0]        opnd_bytes,
    output logic              page_cross,
    output logic              mode_err
);
    localparam int AW = 2 * DW;

    seq_state_t        state_q, state_d;
    logic [MODE_W-1:0] mode_q;
    logic [AW-1:0]     pc_q;
    logic [DW-1:0]     x_q, y_q, lo_q, ptr_q, ptr_now;
    logic [AW-1:0]     eff_q;
    logic [1:0]        bytes_q;
    logic              page_q, err_q;
    logic              capture;

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = needs_operand(mode) ? ST_OPND_LO : ST_FINISH;
            ST_OPND_LO: begin
                if (is_abs_family(mode_q))      state_d = ST_OPND_HI;
                else if (is_ind_family(mode_q)) state_d = ST_PTR_LO;
                else                            state_d = ST_FINISH;
            end
            ST_OPND_HI: state_d = ST_FINISH;
            ST_PTR_LO:  state_d = ST_PTR_HI;
            ST_PTR_HI:  state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign ptr_now = rd_data + ((mode_q == AM_INX) ? x_q : '0);
    assign capture = (state_d == ST_FINISH);

    // output process: read port and adder operands
    always_comb begin
        rd_en   = 1'b0;
        rd_addr = '0;
        c_mode  = mode_q;
        c_x     = x_q;
        c_y     = y_q;
        c_base  = pc_q;
        unique case (state_q)
            ST_IDLE: begin
                rd_en   = start && needs_operand(mode);
                rd_addr = pc;
                c_mode  = mode;
                c_x     = idx_x;
                c_y     = idx_y;
                c_base  = pc;
            end
            ST_OPND_LO: begin
                c_base = {{DW{1'b0}}, rd_data};
                if (is_abs_family(mode_q)) begin
                    rd_en   = 1'b1;
                    rd_addr = pc_q + 1'b1;
                end else if (is_ind_family(mode_q)) begin
                    rd_en   = 1'b1;
                    rd_addr = {{DW{1'b0}}, ptr_now};
                end
            end
            ST_OPND_HI: c_base = {rd_data, lo_q};
            ST_PTR_LO: begin
                rd_en   = 1'b1;
                rd_addr = {{DW{1'b0}}, ptr_q + 1'b1};
            end
            ST_PTR_HI: c_base = {rd_data, lo_q};
            ST_FINISH: ;
            default: ;
        endcase
    end

    // state register and captured data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            pc_q    <= '0;
            x_q     <= '0;
            y_q     <= '0;
            lo_q    <= '0;
            ptr_q   <= '0;
            eff_q   <= '0;
            bytes_q <= '0;
            page_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                mode_q <= mode;
                pc_q   <= pc;
                x_q    <= idx_x;
                y_q    <= idx_y;
            end
            if (state_q == ST_OPND_LO) begin
                lo_q  <= rd_data;
                ptr_q <= ptr_now;
            end
            if (state_q == ST_PTR_LO) lo_q <= rd_data;
            if (capture) begin
                eff_q   <= c_eff;
                bytes_q <= c_bytes;
                page_q  <= c_page;
                err_q   <= c_err;
            end
        end
    end

    assign done       = (state_q == ST_FINISH);
    assign eff_addr   = eff_q;
    assign opnd_bytes = bytes_q;
    assign page_cross = page_q;
    assign mode_err   = err_q;

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> $stable(eff_addr));

    // R6
    ptr_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PTR_LO) |-> (rd_en && rd_addr[AW-1:DW] == '0));

    // R3
    zp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_q == AM_ZPG || mode_q == AM_ZPX || mode_q == AM_ZPY))
            |-> (eff_addr[AW-1:DW] == '0));

    // R8
    page_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && page_cross) |-> (mode_q == AM_ABX || mode_q == AM_ABY || mode_q == AM_INY));

    // R9
    err_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_err) |-> (eff_addr == '0 && opnd_bytes == 2'd0 && !page_cross));

    // R10
    quiet_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPND_HI || state_q == ST_PTR_HI || state_q == ST_FINISH) |-> !rd_en);

endmodule

// File: rtl/opnd_addr_seq.sv
module opnd_addr_seq
    import opnd_addr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [2*DW-1:0]   pc,
    input  logic [DW-1:0]     idx_x,
    input  logic [DW-1:0]     idx_y,
    output logic              rd_en,
    output logic [2*DW-1:0]   rd_addr,
    input  logic [DW-1:0]     rd_data,
    output logic              done,
    output logic [2*DW-1:0]   eff_addr,
    output logic [1:0]        opnd_bytes,
    output logic              page_cross,
    output logic              mode_err
);
    localparam int AW = 2 * DW;

    logic [MODE_W-1:0] c_mode;
    logic [AW-1:0]     c_base, c_eff;
    logic [DW-1:0]     c_x, c_y;
    logic [1:0]        c_bytes;
    logic              c_page, c_err;

    opnd_addr_fsm #(.DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode       (mode),
        .pc         (pc),
        .idx_x      (idx_x),
        .idx_y      (idx_y),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .c_mode     (c_mode),
        .c_base     (c_base),
        .c_x        (c_x),
        .c_y        (c_y),
        .c_eff      (c_eff),
        .c_page     (c_page),
        .c_bytes    (c_bytes),
        .c_err      (c_err),
        .done       (done),
        .eff_addr   (eff_addr),
        .opnd_bytes (opnd_bytes),
        .page_cross (page_cross),
        .mode_err   (mode_err)
    );

    opnd_addr_calc #(.DW(DW)) u_calc (
        .mode       (c_mode),
        .base       (c_base),
        .idx_x      (c_x),
        .idx_y      (c_y),
        .eff        (c_eff),
        .page_cross (c_page),
        .nbytes     (c_bytes),
        .mode_err   (c_err)
    );

endmodule

// File: tb/sim_opnd_addr_seq.sv
`timescale 1ns/1ps
module sim_opnd_addr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [15:0] pc = '0;
    logic [7:0]  ix = '0;
    logic [7:0]  iy = '0;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data = '0;
    logic        done;
    logic [15:0] eff_addr;
    logic [1:0]  opnd_bytes;
    logic        page_cross;
    logic        mode_err;

    int   checks = 0;
    int   errors = 0;
    int   rd_cnt = 0;
    bit   finished = 0;
    logic [7:0]  salt = 8'h00;
    logic [15:0] ov_a [4];
    logic [7:0]  ov_d [4];
    int   ov_n = 0;

    always #2.5 clk = ~clk;

    opnd_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc(pc),
        .idx_x(ix), .idx_y(iy), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .done(done), .eff_addr(eff_addr),
        .opnd_bytes(opnd_bytes), .page_cross(page_cross), .mode_err(mode_err)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        logic [7:0] v;
        for (int i = 0; i < ov_n; i++) if (ov_a[i] == a) return ov_d[i];
        v = (a[7:0] * 8'd37) ^ (a[15:8] * 8'd91) ^ salt;
        return v;
    endfunction

    // memory with one cycle of read latency
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem_byte(rd_addr);
            rd_cnt  <= rd_cnt + 1;
        end
    end

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'd0:             return "R2";
            4'd1, 4'd2, 4'd3: return "R3";
            4'd4:             return "R4";
            4'd5, 4'd6:       return "R5";
            4'd7:             return "R6";
            4'd8:             return "R7";
            default:          return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model(input logic [3:0] m, input logic [15:0] p,
                         input logic [7:0] x, input logic [7:0] y,
                         output logic [15:0] ea, output logic pcf,
                         output logic [1:0] nb, output logic er,
                         output int lat, output int nrd);
        logic [7:0]  op, lo, hi, ptr, ptr1;
        logic [15:0] base, p1;
        ea = '0; pcf = 0; nb = 2'd1; er = 0; lat = 1; nrd = 0;
        op = mem_byte(p);
        p1 = p + 16'd1;
        case (m)
            4'd0: ea = p;
            4'd1: begin ea = {8'h00, op}; lat = 2; nrd = 1; end
            4'd2: begin ptr = op + x; ea = {8'h00, ptr}; lat = 2; nrd = 1; end
            4'd3: begin ptr = op + y; ea = {8'h00, ptr}; lat = 2; nrd = 1; end
            4'd4, 4'd5, 4'd6: begin
                base = {mem_byte(p1), op};
                ea = base + {8'h00, (m == 4'd5) ? x : (m == 4'd6) ? y : 8'h00};
                pcf = (m != 4'd4) && (ea[15:8] != base[15:8]);
                nb = 2'd2; lat = 3; nrd = 2;
            end
            4'd7: begin
                ptr = op + x; ptr1 = ptr + 8'd1;
                lo = mem_byte({8'h00, ptr}); hi = mem_byte({8'h00, ptr1});
                ea = {hi, lo}; lat = 4; nrd = 3;
            end
            4'd8: begin
                ptr1 = op + 8'd1;
                lo = mem_byte({8'h00, op}); hi = mem_byte({8'h00, ptr1});
                base = {hi, lo};
                ea = base + {8'h00, y};
                pcf = (ea[15:8] != base[15:8]);
                lat = 4; nrd = 3;
            end
            default: begin er = 1; nb = 2'd0; end
        endcase
    endtask

    task automatic run(input logic [3:0] m, input logic [15:0] p,
                       input logic [7:0] x, input logic [7:0] y, input bit poke);
        logic [15:0] ea; logic pcf; logic [1:0] nb; logic er;
        int lat, nrd, r0, n;
        string t;
        model(m, p, x, y, ea, pcf, nb, er, lat, nrd);
        t = tag_of(m);
        @(negedge clk);
        mode = m; pc = p; ix = x; iy = y; start = 1'b1;
        r0 = rd_cnt;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                start = 1'b0;
                if (poke) begin start = 1'b1; mode = 4'd0; pc = ~p; end
            end
            if (n == 2) start = 1'b0;
        end while (!done && n < 12);
        start = 1'b0;
        chk("R1", "latency", n, lat);
        chk(t, "eff_addr", eff_addr, ea);
        chk("R8", "page_cross", page_cross, pcf);
        chk(t, "opnd_bytes", opnd_bytes, nb);
        chk("R9", "mode_err", mode_err, er);
        chk("R10", "read count", rd_cnt - r0, nrd);
        @(negedge clk);
        chk("R1", "done one cycle", done, 0);
        repeat (2) begin
            @(negedge clk);
            if (poke) chk("R11", "no extra done", done, 0);
        end
        chk("R11", "address held", eff_addr, ea);
    endtask

    task automatic set_ov(input int k, input logic [15:0] a, input logic [7:0] d);
        ov_a[k] = a; ov_d[k] = d;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R12", "done in reset", done, 0);
        chk("R12", "rd_en in reset", rd_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "done after reset", done, 0);
        chk("R12", "eff_addr after reset", eff_addr, 0);
        chk("R12", "flags after reset", {page_cross, mode_err, opnd_bytes}, 0);

        // R2 immediate
        run(4'd0, 16'hBEEF, 8'h11, 8'h22, 0);
        // R3 page-zero index wraps
        ov_n = 1; set_ov(0, 16'h0200, 8'hF0);
        run(4'd2, 16'h0200, 8'h20, 8'h00, 0);
        run(4'd3, 16'h0200, 8'h00, 8'h10, 0);
        run(4'd1, 16'h0200, 8'hAA, 8'hBB, 0);
        // R4 operand bytes straddling the top of memory
        ov_n = 2; set_ov(0, 16'hFFFF, 8'h34); set_ov(1, 16'h0000, 8'h12);
        run(4'd4, 16'hFFFF, 8'h00, 8'h00, 0);
        chk("R4", "wrapped operand fetch", eff_addr, 16'h1234);
        // R5 carry into high byte, and full wrap
        ov_n = 2; set_ov(0, 16'h3000, 8'hF0); set_ov(1, 16'h3001, 8'h12);
        run(4'd5, 16'h3000, 8'h20, 8'h00, 0);
        chk("R8", "absolute X crossing", page_cross, 1);
        ov_n = 2; set_ov(0, 16'h3000, 8'hFF); set_ov(1, 16'h3001, 8'hFF);
        run(4'd6, 16'h3000, 8'h00, 8'h01, 0);
        chk("R5", "full wrap to zero", eff_addr, 16'h0000);
        // R6 pointer at 0xFF takes its high byte from 0x00
        ov_n = 4; set_ov(0, 16'h4000, 8'h80); set_ov(1, 16'h00FF, 8'h78);
        set_ov(2, 16'h0000, 8'h56); set_ov(3, 16'h0100, 8'h99);
        run(4'd7, 16'h4000, 8'h7F, 8'h00, 0);
        chk("R6", "pointer wrap", eff_addr, 16'h5678);
        // R7 pointer wrap and crossing
        ov_n = 4; set_ov(0, 16'h4000, 8'hFF); set_ov(1, 16'h00FF, 8'h80);
        set_ov(2, 16'h0000, 8'h21); set_ov(3, 16'h0100, 8'h99);
        run(4'd8, 16'h4000, 8'h00, 8'h90, 0);
        chk("R7", "indirect indexed", eff_addr, 16'h2210);
        // R9 no-operand codes
        ov_n = 0;
        run(4'd9, 16'h1234, 8'h01, 8'h02, 0);
        run(4'd15, 16'hFFFF, 8'hFF, 8'hFF, 0);
        // R11 start while busy
        run(4'd8, 16'h5A5A, 8'h03, 8'hC7, 1);
        run(4'd0, 16'h0042, 8'h00, 8'h00, 1);

        for (int i = 0; i < 400; i++) begin
            salt = 8'($urandom);
            run(4'($urandom % 13), 16'($urandom), 8'($urandom), 8'($urandom), ($urandom % 8) == 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule